// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds the contents of one operand register into another, one bit per clock, with a single full adder and a saved carry bit. Both registers shift right, so the least significant bits meet at the adder first. The sum bit is fed back into the top of the accumulator register while the addend register feeds its own outgoing bit back into itself. After one pass over all bits the accumulator holds the sum and the addend is back where it started.

The operand registers have no parallel access. They are filled from a single serial data pin. Each register's current bit 0 is visible on its own output pin, so a load brings the previous contents out least significant bit first, which is how a user reads a result. A small controller sequences each operation over exactly WIDTH shift cycles. While an operation runs it shows busy, and it pulses done when the operation ends. The carry out of the last add is kept as an overflow flag.

Top module: `ser_add_top`

## Requirements
- R1: After a synchronous active-high reset, busy, done and ovf are 0 and both registers read back as zero.
- R2: When idle, a start_load pulse with load_sel=0 (register A) or load_sel=1 (register B) shifts din into that register on each of the next WIDTH clocks. The first bit taken ends in bit 0 and the last in the MSB. The other register is untouched.
- R3: The a_lsb and b_lsb outputs always show bit 0 of registers A and B, so the old contents come out least significant bit first during a load.
- R4: When idle, a start_add pulse makes register A equal (A + B) mod 2^WIDTH after WIDTH shift cycles.
- R5: After an add, register B holds the same value it held before the add.
- R6: ovf gives the carry out of the most significant bit of the last add. It holds that value until the next accepted start_add, which clears it.
- R7: The saved carry is cleared when an add is accepted, so a carry left over from an earlier add never changes a result.
- R8: busy is high for exactly WIDTH cycles after the clock edge that accepts a request. done is high for the one cycle that follows, with busy low.
- R9: A start_add or start_load that arrives while busy is ignored. Neither register, ovf nor the timing changes.
- R10: If start_add and start_load are both high while idle, the add runs and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_add | input | 1 | Request A = A + B |
| start_load | input | 1 | Request a serial load |
| load_sel | input | 1 | Load target: 0 = A, 1 = B |
| din | input | 1 | Serial load data, LSB first |
| a_lsb | output | 1 | Current bit 0 of register A |
| b_lsb | output | 1 | Current bit 0 of register B |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse after an operation ends |
| ovf | output | 1 | Carry out of the last add |

## Verification
The bench builds the block with WIDTH=4. At that width every one of the 256 operand pairs can be added and checked against arithmetic sums in a short run. This covers all carry chains, every overflow case, and adds that follow an overflowing add with the carry left set. The width-independent control cases are tested directly on the same build: requests during an operation, both requests at once, and reset state.

// File: rtl/ser_add_pkg.sv
package ser_add_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADD  = 2'd1,
        ST_LOAD = 2'd2
    } op_state_e;

    // mux select encoding shared by the controller and the datapath
    localparam logic SEL_ADD_PATH = 1'b0;
    localparam logic SEL_DATA_IN  = 1'b1;

endpackage

// File: rtl/ser_add_ctrl.sv
module ser_add_ctrl
    import ser_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_add_i,
    input  logic start_load_i,
    input  logic load_sel_i,
    output logic busy_o,
    output logic done_o,
    output logic shift_a_o,
    output logic shift_b_o,
    output logic mux_a_sel_o,
    output logic mux_b_sel_o,
    output logic clr_carry_o,
    output logic add_step_o,
    output logic last_add_o
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        op_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             tgt;
        logic             done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{state: ST_IDLE, cnt: '0, tgt: 1'b0, done: 1'b0};

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        clr_carry_o = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_add_i) begin
                    ctrl_d.state = ST_ADD;
                    ctrl_d.cnt   = '0;
                    clr_carry_o  = 1'b1;
                end else if (start_load_i) begin
                    ctrl_d.state = ST_LOAD;
                    ctrl_d.cnt   = '0;
                    ctrl_d.tgt   = load_sel_i;
                end
            end
            default: begin
                ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.state = ST_IDLE;
                    ctrl_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RST;
        else     ctrl_q <= ctrl_d;
    end

    always_comb begin
        busy_o      = (ctrl_q.state != ST_IDLE);
        done_o      = ctrl_q.done;
        add_step_o  = (ctrl_q.state == ST_ADD);
        last_add_o  = add_step_o && (ctrl_q.cnt == LAST);
        shift_a_o   = add_step_o || ((ctrl_q.state == ST_LOAD) && !ctrl_q.tgt);
        shift_b_o   = add_step_o || ((ctrl_q.state == ST_LOAD) && ctrl_q.tgt);
        mux_a_sel_o = (ctrl_q.state == ST_LOAD) ? SEL_DATA_IN : SEL_ADD_PATH;
        mux_b_sel_o = (ctrl_q.state == ST_LOAD) ? SEL_DATA_IN : SEL_ADD_PATH;
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ctrl_q.cnt != LAST) |=> (busy_o && ctrl_q.cnt == $past(ctrl_q.cnt) + 1'b1)); // R8
    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ctrl_q.cnt != LAST) |=> ($stable(ctrl_q.tgt) && ctrl_q.state == $past(ctrl_q.state))); // R9
    AST_ADD_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_add_i) |=> add_step_o); // R10

endmodule

// File: rtl/ser_add_shreg.sv
module ser_add_shreg #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic sin_i,
    output logic lsb_o
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) begin
            if (WIDTH > 1) sr_d.bits = {sin_i, sr_q.bits[WIDTH-1:1]};
            else           sr_d.bits = sin_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign lsb_o = sr_q.bits[0];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(sr_q.bits)); // R2
    AST_SIN_TO_MSB: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (sr_q.bits[WIDTH-1] == $past(sin_i))); // R2

endmodule

// File: rtl/ser_add_bitalu.sv
module ser_add_bitalu (
    input  logic clk,
    input  logic rst,
    input  logic a_bit_i,
    input  logic b_bit_i,
    input  logic clr_carry_i,
    input  logic step_i,
    input  logic last_i,
    output logic sum_o,
    output logic ovf_o
);

    typedef struct packed {
        logic carry;
        logic ovf;
    } alu_t;

    alu_t alu_d, alu_q;
    logic cout;

    always_comb begin
        sum_o = a_bit_i ^ b_bit_i ^ alu_q.carry;
        cout  = (a_bit_i & b_bit_i) | (alu_q.carry & (a_bit_i ^ b_bit_i));
        alu_d = alu_q;
        if (clr_carry_i) begin
            alu_d.carry = 1'b0;
            alu_d.ovf   = 1'b0;
        end else if (step_i) begin
            alu_d.carry = cout;
            if (last_i) alu_d.ovf = cout;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) alu_q <= '0;
        else     alu_q <= alu_d;
    end

    assign ovf_o = alu_q.ovf;

    AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr_carry_i |=> (alu_q.carry == 1'b0 && ovf_o == 1'b0)); // R7
    AST_OVF_HELD: assert property (@(posedge clk) disable iff (rst)
        (!clr_carry_i && !last_i) |=> $stable(ovf_o)); // R6

endmodule

// File: rtl/ser_add_top.sv
module ser_add_top
    import ser_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_add,
    input  logic start_load,
    input  logic load_sel,
    input  logic din,
    output logic a_lsb,
    output logic b_lsb,
    output logic busy,
    output logic done,
    output logic ovf
);

    logic shift_a, shift_b, mux_a_sel, mux_b_sel;
    logic clr_carry, add_step, last_add;
    logic sum_bit, a_sin, b_sin;

    ser_add_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_add_i (start_add),
        .start_load_i(start_load),
        .load_sel_i  (load_sel),
        .busy_o      (busy),
        .done_o      (done),
        .shift_a_o   (shift_a),
        .shift_b_o   (shift_b),
        .mux_a_sel_o (mux_a_sel),
        .mux_b_sel_o (mux_b_sel),
        .clr_carry_o (clr_carry),
        .add_step_o  (add_step),
        .last_add_o  (last_add)
    );

    // serial-input multiplexers: add path feeds sum to A, recirculates B
    assign a_sin = (mux_a_sel == SEL_DATA_IN) ? din : sum_bit;
    assign b_sin = (mux_b_sel == SEL_DATA_IN) ? din : b_lsb;

    ser_add_shreg #(.WIDTH(WIDTH)) u_reg_a (
        .clk    (clk),
        .rst    (rst),
        .shift_i(shift_a),
        .sin_i  (a_sin),
        .lsb_o  (a_lsb)
    );

    ser_add_shreg #(.WIDTH(WIDTH)) u_reg_b (
        .clk    (clk),
        .rst    (rst),
        .shift_i(shift_b),
        .sin_i  (b_sin),
        .lsb_o  (b_lsb)
    );

    ser_add_bitalu u_alu (
        .clk        (clk),
        .rst        (rst),
        .a_bit_i    (a_lsb),
        .b_bit_i    (b_lsb),
        .clr_carry_i(clr_carry),
        .step_i     (add_step),
        .last_i     (last_add),
        .sum_o      (sum_bit),
        .ovf_o      (ovf)
    );

    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_add || start_load)); // R8
    AST_OVF_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_add) |=> $stable(ovf)); // R6

endmodule

// File: tb/ser_add_top_test.sv
module ser_add_top_test;

    localparam int W = 4;
    localparam int MAXV = 1 << W;

    logic clk = 1'b0;
    logic rst, start_add, start_load, load_sel, din;
    logic a_lsb, b_lsb, busy, done, ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ser_add_top #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .start_add(start_add), .start_load(start_load),
        .load_sel(load_sel), .din(din), .a_lsb(a_lsb), .b_lsb(b_lsb),
        .busy(busy), .done(done), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // serial load; returns old contents (R2, R3); optional add request injected at step inj_k
    task automatic do_load(input logic sel, input logic [W-1:0] val, input int inj_k,
                           output logic [W-1:0] old, output bit timing_ok);
        timing_ok = 1'b1;
        @(negedge clk);
        start_load = 1'b1;
        load_sel   = sel;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            start_load = 1'b0;
            start_add  = (k == inj_k);
            din        = val[k];
            old[k]     = sel ? b_lsb : a_lsb;
            if (!busy || done) timing_ok = 1'b0;
        end
        @(negedge clk);
        start_add = 1'b0;
        if (busy || !done) timing_ok = 1'b0;
        @(negedge clk);
        if (done) timing_ok = 1'b0;
    endtask

    // add; optional load request (target B, data 1) injected at step inj_k
    task automatic do_add(input int inj_k, input bit also_load, output bit timing_ok);
        timing_ok = 1'b1;
        @(negedge clk);
        start_add  = 1'b1;
        start_load = also_load;
        load_sel   = 1'b0;
        din        = 1'b1;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            start_add  = 1'b0;
            start_load = (k == inj_k);
            load_sel   = 1'b1;
            if (!busy || done) timing_ok = 1'b0;
        end
        @(negedge clk);
        start_load = 1'b0;
        if (busy || !done) timing_ok = 1'b0;
        @(negedge clk);
        if (done) timing_ok = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] old;
        logic [W-1:0] exp_sum;
        bit tok;
        bit exp_ovf;
        rst = 1'b1; start_add = 1'b0; start_load = 1'b0; load_sel = 1'b0; din = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(!busy && !done && !ovf, "R1 flags", {busy, done, ovf}, 0);
        do_load(1'b0, '0, -1, old, tok);
        chk(old == 0, "R1 reg A", old, 0);
        do_load(1'b1, '0, -1, old, tok);
        chk(old == 0, "R1 reg B", old, 0);

        // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8
        for (int a = 0; a < MAXV; a++) begin
            for (int b = 0; b < MAXV; b++) begin
                do_load(1'b0, W'(a), -1, old, tok);
                do_load(1'b1, W'(b), -1, old, tok);
                chk(tok, "R8 load timing", tok, 1);
                do_add(-1, 1'b0, tok);
                chk(tok, "R8 add timing", tok, 1);
                exp_sum = W'(a + b);
                exp_ovf = (a + b) >= MAXV;
                chk(ovf == exp_ovf, "R6 overflow", ovf, exp_ovf);
                do_load(1'b0, '0, -1, old, tok);
                chk(old == exp_sum, "R4 R7 sum", old, exp_sum);
                chk(ovf == exp_ovf, "R6 ovf held over load", ovf, exp_ovf);
                do_load(1'b1, '0, -1, old, tok);
                chk(old == W'(b), "R5 R2 B kept", old, b);
            end
        end

        // R9 load request during add ignored; then add request during load ignored
        do_load(1'b0, W'(12), -1, old, tok);
        do_load(1'b1, W'(7), -1, old, tok);
        do_add(1, 1'b0, tok);
        chk(tok, "R9 add timing with stray load", tok, 1);
        chk(ovf == 1'b1, "R9 ovf", ovf, 1);
        do_load(1'b0, W'(9), 1, old, tok);
        chk(old == W'(3), "R9 sum with stray load", old, 3);
        chk(tok, "R9 load timing with stray add", tok, 1);
        chk(ovf == 1'b1, "R9 ovf kept after stray add", ovf, 1);
        do_load(1'b1, W'(2), -1, old, tok);
        chk(old == W'(7), "R9 B kept with stray load", old, 7);
        do_load(1'b0, '0, -1, old, tok);
        chk(old == W'(9), "R9 A load intact", old, 9);

        // R10 both requests at once: add wins
        do_load(1'b0, W'(5), -1, old, tok);
        do_load(1'b1, W'(3), -1, old, tok);
        do_add(-1, 1'b1, tok);
        chk(tok, "R10 timing", tok, 1);
        chk(ovf == 1'b0, "R10 ovf", ovf, 0);
        do_load(1'b0, '0, -1, old, tok);
        chk(old == W'(8), "R10 sum", old, 8);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule